// File: doc/BRIEF.md
# Link Status Change Detector

This block watches a link-status pin from an external transceiver and keeps a sticky flag that records any change of the link level. The pin first passes through a synchronizer. The synchronized level is then gated to 0 in two cases: when the shared pin is assigned to general-purpose port use, or while the controller is held in software reset. The result is the effective link level. The flag sets on every edge of the effective level, whether it rises or falls.

Because of the gating, the flag can set even when the pin itself stays constant. If the pin is high while the port select or the soft reset is released, the effective level goes from 0 to 1 and the flag sets.

Software uses a small two-address register interface. Through it, software reads the flag and the current effective level, clears the flag by writing a one to it, and programs an interrupt enable. A single level interrupt is raised while the flag and the enable are both 1. Software should clear any stale flag before it sets the enable.

Top module: `link_change_detect`

## Requirements
- R1: After reset, the flag, the interrupt enable and the interrupt output are all 0, and both read addresses return 0.
- R2: A 0-to-1 change of the effective level sets the flag. The pin goes through two synchronizer flops, so the flag reads 1 after the third rising clock edge that follows the pin change.
- R3: A 1-to-0 change of the effective level also sets the flag, with the same latency as R2.
- R4: While port_mode_i is 1, the effective level is 0 and a pin change does not set the flag.
- R5: While soft_reset_i is 1, the effective level is 0 and a pin change does not set the flag.
- R6: If port_mode_i or soft_reset_i is released while the synchronized pin is 1, the flag sets on the next rising edge, even though the pin did not move.
- R7: A write to address 0 with data bit 0 set clears the flag. A write to address 0 with data bit 0 clear leaves the flag unchanged.
- R8: If a change of the effective level and a clearing write fall in the same cycle, the flag is 1 afterwards.
- R9: Address 1 bit 0 is the interrupt enable. It is read/write. irq_o equals flag AND enable.
- R10: A read of address 0 returns the flag in bit 0 and the current effective level in bit 1. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_pin_i | input | 1 | Asynchronous link-status pin |
| port_mode_i | input | 1 | 1 = pin is assigned to general-purpose port use; forces the effective level to 0 |
| soft_reset_i | input | 1 | 1 = controller in software reset; forces the effective level to 0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 = status, 1 = control |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt: flag AND enable |

## Verification
Two functions can act on the flag in the same cycle: a set caused by a level change and a clear caused by a write-one. The directed part of the bench forces this collision by releasing soft reset with the pin high in the same cycle that it writes the clear. The bench then expects the flag to read 1. The random part drives the pin, the two masks and the clearing writes independently, so collisions of pin-driven changes with clears also occur. A cycle model in the bench scores every read and the interrupt in each cycle.

// File: rtl/link_change_detect.sv
module link_change_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_pin_i,
  input  logic              port_mode_i,
  input  logic              soft_reset_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int FLAG_BIT  = 0;
  localparam int LEVEL_BIT = 1;
  localparam int IEN_BIT   = 0;

  logic [SYNC_STAGES-1:0] sync_q;
  logic level_q, flag_q, ien_q;
  logic eff_level, change, clr_req;
  logic unused_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], link_pin_i};

  assign eff_level = sync_q[SYNC_STAGES-1] & ~port_mode_i & ~soft_reset_i;
  assign change    = eff_level ^ level_q;
  assign clr_req   = reg_wr_i & ~reg_addr_i & reg_wdata_i[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      level_q <= 1'b0;
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      level_q <= eff_level;
      flag_q  <= change | (flag_q & ~clr_req);
      if (reg_wr_i && reg_addr_i) ien_q <= reg_wdata_i[IEN_BIT];
    end

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_addr_i) begin
      reg_rdata_o[FLAG_BIT]  = flag_q;
      reg_rdata_o[LEVEL_BIT] = eff_level;
    end else begin
      reg_rdata_o[IEN_BIT] = ien_q;
    end
  end

  assign irq_o = flag_q & ien_q;
  assign unused_wdata = ^reg_wdata_i;
endmodule

// File: rtl/link_change_detect_chk.sv
module link_change_detect_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_mode_i,
  input logic              soft_reset_i,
  input logic              reg_wr_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              eff_level,
  input logic              level_q,
  input logic              flag_q,
  input logic              ien_q
);
  assert_change_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_level != level_q) |=> flag_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff_level != level_q) && reg_wr_i && !reg_addr_i && reg_wdata_i[0]) |=> flag_q);

  assert_port_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_mode_i |=> !level_q);

  assert_sreset_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_i |=> !level_q);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && (eff_level == level_q) && reg_wr_i && !reg_addr_i && reg_wdata_i[0]) |=> !flag_q);

  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && (eff_level == level_q)) |=> !flag_q);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq_o);
endmodule

bind link_change_detect link_change_detect_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_mode_i(port_mode_i), .soft_reset_i(soft_reset_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .irq_o(irq_o), .eff_level(eff_level), .level_q(level_q), .flag_q(flag_q), .ien_q(ien_q));

// File: tb/sim_link_change_detect.sv
`timescale 1ns/1ps
module sim_link_change_detect;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 0, pm = 0, sr = 0, wr = 0, addr = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;
  int vectors = 0, errors = 0;
  logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_flag = 0, m_ien = 0;

  always #10 clk = ~clk;

  link_change_detect #(.SYNC_STAGES(2), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .link_pin_i(pin), .port_mode_i(pm), .soft_reset_i(sr),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic exp_level();
    return m_s2 & ~pm & ~sr;
  endfunction

  function automatic logic [DW-1:0] exp_read();
    logic [DW-1:0] r = '0;
    if (!addr) begin r[0] = m_flag; r[1] = exp_level(); end
    else r[0] = m_ien;
    return r;
  endfunction

  task automatic check(string tag);
    vectors++;
    if (rdata !== exp_read()) begin
      errors++;
      $display("FAIL %s read addr=%0d actual=%h expected=%h", tag, addr, rdata, exp_read());
    end
    vectors++;
    if (irq !== (m_flag & m_ien)) begin
      errors++;
      $display("FAIL R9 irq (%s) actual=%0b expected=%0b", tag, irq, m_flag & m_ien);
    end
  endtask

  task automatic step(logic p, logic m, logic s, logic w, logic a, logic [DW-1:0] d, string tag);
    logic lvl, chg, clr;
    pin = p; pm = m; sr = s; wr = w; addr = a; wdata = d;
    #1 check(tag);
    @(posedge clk);
    lvl = exp_level();
    chg = lvl ^ m_prev;
    clr = w & ~a & d[0];
    m_flag = chg | (m_flag & ~clr);
    if (w && a) m_ien = d[0];
    m_prev = lvl; m_s2 = m_s1; m_s1 = p;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1"); addr = 1; #1 check("R1"); addr = 0;
    rst_n = 1;
    @(negedge clk);
    step(0,0,0,1,1,8'h01,"R9");
    step(0,0,0,0,1,8'h00,"R9");
    repeat (4) step(1,0,0,0,0,8'h00,"R2");
    step(1,0,0,1,0,8'h00,"R7");
    step(1,0,0,1,0,8'h01,"R7");
    repeat (4) step(0,0,0,0,0,8'h00,"R3");
    step(0,0,0,1,0,8'h01,"R7");
    repeat (5) step(1,1,0,0,0,8'h00,"R4");
    repeat (3) step(1,0,0,0,0,8'h00,"R6");
    step(1,0,0,1,0,8'h01,"R10");
    repeat (5) step(1,0,1,0,0,8'h00,"R5");
    step(1,0,1,1,0,8'h01,"R5");
    step(1,0,0,1,0,8'h01,"R8");
    repeat (2) step(1,0,0,0,0,8'h00,"R8");
    step(1,0,0,1,0,8'hFE,"R7");
    step(1,0,0,0,0,8'h00,"R7");
    step(1,0,0,1,1,8'h00,"R9");
    step(1,0,0,0,1,8'h00,"R9");
    for (int i = 0; i < 4000; i++) begin
      logic p = ($urandom_range(0, 3) == 0) ? ~pin : pin;
      logic m = ($urandom_range(0, 15) == 0) ? ~pm : pm;
      logic s = ($urandom_range(0, 15) == 0) ? ~sr : sr;
      logic w = ($urandom_range(0, 2) == 0);
      logic a = $urandom_range(0, 1);
      logic [DW-1:0] d = DW'($urandom);
      step(p, m, s, w, a, d, "R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule